// File: doc/BRIEF.md
# Dual-Clock Dual-Port RAM with Burst Address Counters

This block models a synchronous static memory with two independent ports, A and B. Each port has its own clock and can read and write one shared array of `2**ADDR_W` words, each `DATA_W` bits wide. Per-port signals are packed into two-bit or two-slice vectors. Index 0 (the low slice) is port A and index 1 (the high slice) is port B.

Every port captures its address, data and control on the rising edge of its clock. The address does not go straight to the array. It passes through a per-port counter that can be cleared, loaded from the `addr` pins, advanced by one, or held. A burst can therefore be streamed from a single start address and paused at any point.

A port is selected only while its active-low enable is low and its active-high enable is high. Because of this, two instances can share one address range: wire the top address bit to `cs_n` of one instance and to `cs` of the other, and tie the remaining enables to their active levels. No extra logic is needed. Each port chooses flow-through or pipelined read output. An unregistered output enable gates the result. A port that is not driving shows `dvalid` low and `dout` all zeros.

Top module: `dpram_ctr`

## Requirements
- R1: At a rising clock edge where the port samples `cs_n` low, `cs` high and `wr_n` low, `din` is written to the address the counter takes at that same edge.
- R2: At every edge the counter follows this priority: `clr_n` low sets it to 0; otherwise `load_n` low loads `addr`; otherwise `inc_n` low adds one, wrapping from `2**ADDR_W-1` to 0; otherwise it holds its value. The counter runs whether or not the port is selected.
- R3: With `pipe` low (flow-through), a read sampled at edge k drives the word at the counter address onto `dout` after edge k, with `dvalid` high.
- R4: With `pipe` high (pipelined), the word addressed at edge k appears on `dout` only after edge k+1.
- R5: An edge that samples the port deselected (`cs_n` high or `cs` low) forces `dvalid` low after that edge in both modes.
- R6: In pipelined mode the port drives data only after two consecutive selected edges. The first selected edge after a deselect yields no output.
- R7: `oe_n` acts without a clock. While it is high, `dvalid` is low and `dout` is zero. When it falls, the pending result reappears at once.
- R8: When both ports write the same address on the same edge, the word from port A is the one kept.
- R9: An edge that performs a write produces no read output afterwards. Whenever `dvalid` is low, `dout` is all zeros.
- R10: While `rst_n` is low, both counters are 0 and `dvalid` is low on both ports. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| clk | input | 2 | Port clocks, bit 0 for A and bit 1 for B |
| cs_n | input | 2 | Active-low enable per port |
| cs | input | 2 | Active-high enable per port |
| wr_n | input | 2 | Low requests a write, high a read |
| load_n | input | 2 | Low loads the counter from `addr` |
| inc_n | input | 2 | Low advances the counter by one |
| clr_n | input | 2 | Low clears the counter |
| oe_n | input | 2 | Active-low asynchronous output enable |
| pipe | input | 2 | 1 selects pipelined output, 0 flow-through |
| addr | input | 2*ADDR_W | External addresses, A in the low slice |
| din | input | 2*DATA_W | Write data, A in the low slice |
| dout | output | 2*DATA_W | Read data, zero when not driving |
| dvalid | output | 2 | High while the port drives `dout` |

## Verification
The bench writes both ports to one word on the same edge. A design that resolved this collision by clock order, or in favour of port B, would return B's data. It walks the counter through clear, load and increment given together, and through the wrap from the top address. A design with the wrong priority would read or write the wrong word.

Pipelined reads are checked right after a single-cycle deselect. A design that re-enables its outputs after one selected edge would show data one cycle early. The bench also toggles `oe_n` between clock edges. A design that registers the output enable would lag by a cycle.

Random traffic over a few hot addresses, plus the top address, mixes all of these cases with reads of freshly written words.

// File: rtl/dpram_ctr.sv
`timescale 1ns/1ps
module dpram_ctr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                  rst_n,
  input  logic [1:0]            clk,
  input  logic [1:0]            cs_n,
  input  logic [1:0]            cs,
  input  logic [1:0]            wr_n,
  input  logic [1:0]            load_n,
  input  logic [1:0]            inc_n,
  input  logic [1:0]            clr_n,
  input  logic [1:0]            oe_n,
  input  logic [1:0]            pipe,
  input  logic [2*ADDR_W-1:0]   addr,
  input  logic [2*DATA_W-1:0]   din,
  output logic [2*DATA_W-1:0]   dout,
  output logic [1:0]            dvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic              live_a [DEPTH];
  logic              live_b [DEPTH];

  logic [2*ADDR_W-1:0] addr_nx;
  logic [1:0]          wr_nx;

  function automatic logic [DATA_W-1:0] fetch(input logic [ADDR_W-1:0] a);
    return (live_a[a] != live_b[a]) ? bank_a[a] : bank_b[a];
  endfunction

  wire [ADDR_W-1:0] wa = addr_nx[ADDR_W-1:0];
  wire [ADDR_W-1:0] wb = addr_nx[2*ADDR_W-1:ADDR_W];

  always_ff @(posedge clk[0]) begin
    if (wr_nx[0]) begin
      bank_a[wa] <= din[DATA_W-1:0];
      live_a[wa] <= ~live_b[wa];
    end
  end

  always_ff @(posedge clk[1]) begin
    if (wr_nx[1]) begin
      bank_b[wb] <= din[2*DATA_W-1:DATA_W];
      if (!(wr_nx[0] && wa == wb))
        live_b[wb] <= live_a[wb];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [ADDR_W-1:0] addr_q;
    logic              sel_q, rd_q, pv_q;
    logic [DATA_W-1:0] pd_q;
    logic              vld;

    wire sel_in = !cs_n[p] && cs[p];

    assign addr_nx[p*ADDR_W +: ADDR_W] =
      !clr_n[p]  ? '0 :
      !load_n[p] ? addr[p*ADDR_W +: ADDR_W] :
      !inc_n[p]  ? addr_q + 1'b1 : addr_q;
    assign wr_nx[p] = sel_in && !wr_n[p];

    always_ff @(posedge clk[p] or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        sel_q  <= 1'b0;
        rd_q   <= 1'b0;
        pv_q   <= 1'b0;
        pd_q   <= '0;
      end else begin
        addr_q <= addr_nx[p*ADDR_W +: ADDR_W];
        sel_q  <= sel_in;
        rd_q   <= sel_in && wr_n[p];
        pv_q   <= sel_q && rd_q && sel_in;
        pd_q   <= fetch(addr_q);
      end
    end

    assign vld = !oe_n[p] && (pipe[p] ? pv_q : (sel_q && rd_q));
    assign dvalid[p] = vld;
    assign dout[p*DATA_W +: DATA_W] = !vld ? '0 : (pipe[p] ? pd_q : fetch(addr_q));

    p_hold_r2: assert property (@(posedge clk[p]) disable iff (!rst_n)
      (clr_n[p] && load_n[p] && inc_n[p]) |=> $stable(addr_q));
    p_desel_r5: assert property (@(posedge clk[p]) disable iff (!rst_n)
      !sel_in |=> !dvalid[p]);
    p_pipe_wake_r6: assert property (@(posedge clk[p]) disable iff (!rst_n)
      (pipe[p] && !sel_in) |=> ##1 (!pipe[p] || !dvalid[p]));
    p_wrcyc_r9: assert property (@(posedge clk[p]) disable iff (!rst_n)
      (sel_in && !wr_n[p] && !pipe[p]) |=> (pipe[p] || !dvalid[p]));
  end
endmodule

// File: tb/dpram_ctr_bench.sv
`timescale 1ns/1ps
module dpram_ctr_bench;
  localparam int DW = 8;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cs_n, cs, wr_n, load_n, inc_n, clr_n, oe_n, pipe;
  logic [2*AW-1:0] addr;
  logic [2*DW-1:0] din;
  logic [2*DW-1:0] dout;
  logic [1:0] dvalid;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dpram_ctr #(.DATA_W(DW), .ADDR_W(AW)) u_dpram_ctr (
    .rst_n(rst_n), .clk({clk, clk}), .cs_n(cs_n), .cs(cs), .wr_n(wr_n),
    .load_n(load_n), .inc_n(inc_n), .clr_n(clr_n), .oe_n(oe_n), .pipe(pipe),
    .addr(addr), .din(din), .dout(dout), .dvalid(dvalid));

  logic [DW-1:0] mem_m [DEPTH];
  logic [AW-1:0] m_addr [2];
  logic          m_sel [2];
  logic          m_rd [2];
  logic          m_pv [2];
  logic [DW-1:0] m_pd [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_addr[p] = '0; m_sel[p] = 0; m_rd[p] = 0; m_pv[p] = 0; m_pd[p] = '0;
      end
    end else begin
      logic          s [2];
      logic [DW-1:0] rv [2];
      logic [AW-1:0] na [2];
      for (int p = 0; p < 2; p++) begin
        s[p]  = !cs_n[p] && cs[p];
        rv[p] = mem_m[m_addr[p]];
        na[p] = !clr_n[p] ? '0 : !load_n[p] ? addr[p*AW +: AW] :
                !inc_n[p] ? m_addr[p] + 1'b1 : m_addr[p];
      end
      for (int p = 1; p >= 0; p--)
        if (s[p] && !wr_n[p]) mem_m[na[p]] = din[p*DW +: DW];
      for (int p = 0; p < 2; p++) begin
        m_pv[p]   = m_sel[p] && m_rd[p] && s[p];
        m_pd[p]   = rv[p];
        m_addr[p] = na[p];
        m_sel[p]  = s[p];
        m_rd[p]   = s[p] && wr_n[p];
      end
    end
  end

  function automatic logic exp_v(int p);
    return !oe_n[p] && (pipe[p] ? m_pv[p] : (m_sel[p] && m_rd[p]));
  endfunction

  function automatic logic [DW-1:0] exp_d(int p);
    if (!exp_v(p)) return '0;
    return pipe[p] ? m_pd[p] : mem_m[m_addr[p]];
  endfunction

  task automatic chk(string tag, int p);
    string t;
    t = (tag == "") ? (pipe[p] ? "R4" : "R3") : tag;
    vectors++;
    if (dvalid[p] !== exp_v(p) || dout[p*DW +: DW] !== exp_d(p)) begin
      miscompares++;
      $display("FAIL %s port%0d: got dvalid=%0b dout=%h, expected dvalid=%0b dout=%h",
               t, p, dvalid[p], dout[p*DW +: DW], exp_v(p), exp_d(p));
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    #5;
    chk(tag, 0);
    chk(tag, 1);
  endtask

  task automatic setp(int p, bit csn, bit ce, bit wn, bit ln, bit icn, bit crn,
                      logic [AW-1:0] a, logic [DW-1:0] d);
    cs_n[p] = csn; cs[p] = ce; wr_n[p] = wn; load_n[p] = ln;
    inc_n[p] = icn; clr_n[p] = crn;
    addr[p*AW +: AW] = a; din[p*DW +: DW] = d;
  endtask

  task automatic idle(int p);
    setp(p, 1, 0, 1, 1, 1, 1, '0, '0);
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; oe_n = 2'b00; pipe = 2'b00;
    idle(0); idle(1);
    setp(0, 0, 1, 1, 1, 0, 1, '0, '0);
    repeat (3) tick("R10");
    @(negedge clk); rst_n = 1;
    idle(0);

    setp(0, 0, 1, 0, 0, 1, 1, 10'd5, 8'h5A); tick("R9");
    setp(0, 0, 1, 1, 0, 1, 1, 10'd5, 8'h00); tick("R1");
    setp(0, 0, 1, 1, 1, 1, 1, 10'd0, 8'h00); tick("R3");

    setp(0, 0, 1, 0, 0, 1, 1, DEPTH - 1, 8'h11); tick("R2");
    setp(0, 0, 1, 0, 1, 0, 1, '0, 8'h22); tick("R2");
    setp(0, 0, 1, 1, 0, 1, 1, DEPTH - 1, 8'h00); tick("R2");
    setp(0, 0, 1, 1, 0, 1, 1, 10'd0, 8'h00); tick("R2");
    setp(0, 0, 1, 1, 0, 0, 0, 10'd5, 8'h00); tick("R2");
    setp(0, 0, 1, 1, 0, 0, 1, 10'd5, 8'h00); tick("R2");
    setp(0, 0, 1, 1, 1, 0, 1, 10'd5, 8'h00); tick("R2");

    setp(0, 0, 1, 0, 0, 1, 1, 10'd9, 8'hAA);
    setp(1, 0, 1, 0, 0, 1, 1, 10'd9, 8'hBB); tick("R8");
    setp(0, 0, 1, 1, 0, 1, 1, 10'd9, 8'h00);
    setp(1, 0, 1, 1, 0, 1, 1, 10'd9, 8'h00); tick("R8");

    pipe[1] = 1'b1;
    setp(1, 0, 1, 1, 0, 1, 1, 10'd5, 8'h00); tick("R4");
    tick("R4");
    setp(1, 1, 1, 1, 1, 1, 1, 10'd5, 8'h00); tick("R5");
    setp(1, 0, 1, 1, 1, 1, 1, 10'd5, 8'h00); tick("R6");
    tick("R6");
    setp(1, 0, 0, 1, 1, 1, 1, 10'd5, 8'h00); tick("R5");
    setp(1, 0, 1, 1, 1, 1, 1, 10'd5, 8'h00); tick("R6");
    tick("R6");
    setp(0, 0, 0, 1, 1, 1, 1, 10'd5, 8'h00); tick("R5");

    setp(0, 0, 1, 1, 0, 1, 1, 10'd9, 8'h00); tick("R3");
    #2 oe_n = 2'b11; #1 chk("R7", 0); chk("R7", 1);
    #2 oe_n = 2'b00; #1 chk("R7", 0); chk("R7", 1);

    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) pipe = 2'($urandom);
      for (int p = 0; p < 2; p++) begin
        logic [AW-1:0] a;
        a = ($urandom % 5 == 0) ? AW'(DEPTH - 1 - ($urandom % 2)) : AW'($urandom % 8);
        setp(p, ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 3) != 0,
             ($urandom % 4) != 0, ($urandom % 2) != 0, ($urandom % 16) != 0,
             a, DW'($urandom));
      end
      oe_n = {($urandom % 10) == 0, ($urandom % 10) == 0};
      tick("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule